// File: doc/BRIEF.md
# I2S Stereo Sample Receiver

This block is the slave side of a three-wire I2S audio link: bit clock, word select and serial data, all driven by an outside master. It is clocked directly by the bit clock. It rebuilds one 16-bit left sample and one 16-bit right sample per frame, and it presents each finished pair together on two parallel buses with a one-cycle strobe.

The master may run the bit clock at 32 or 64 times the sample rate. The receiver is never told which rate is in use. It counts the bits of each word from the word-select change, keeps the first sixteen bits and drops any padding until the next change. A word that is cut short by an early word-select change is thrown away. After reset, nothing is output until a complete left word has been seen, and that left word must start at a word-select transition.

The control state machine has four states. SYNC holds only the first cycle after reset; it records word select and moves to HUNT. HUNT waits for a word-select change, which moves it to SHIFT. SHIFT captures bits. It moves to PAD once sixteen bits are in. On a word-select change it stays in SHIFT: it either finishes the word, when that edge brings the sixteenth bit, or abandons it, and in both cases it starts a new word. PAD ignores data until a word-select change, which moves it back to SHIFT.

Top module: `i2s_stereo_rx`

## Requirements
- R1: While reset is asserted and right after it, `pair_valid` is 0 and both sample outputs are 0.
- R2: Word select low marks the left channel and high marks the right channel. `left_out` carries the word sent while word select was low.
- R3: Data is captured on the rising bit-clock edge, most significant bit first. The bit captured on the edge after the one where a word-select change is seen is bit 15 of the new word.
- R4: At 16 bit slots per channel, the least significant bit of a word is captured on the edge where the next word-select change is seen, and the word is accepted.
- R5: At 32 bit slots per channel, the 16 bits after bit 0 are padding and have no effect on any output.
- R6: The receiver follows changes between 16 and 32 slots per channel from frame to frame without reset or configuration.
- R7: `pair_valid` is high for exactly one cycle, in the cycle after the edge that captures the last bit of a right word. The sample outputs change only together with that strobe.
- R8: After reset, no pair is output until a full left word has been received, and that left word must have started at a word-select transition.
- R9: A word that is cut short by a word-select change before 16 bits arrive is discarded, and its frame produces no pair.
- R10: No more than 16 bits are counted into any one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock from the master; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ws | input | 1 | Word select: 0 = left channel, 1 = right channel |
| sd | input | 1 | Serial audio data, MSB first, one slot behind word select |
| left_out | output | 16 | Last completed left sample |
| right_out | output | 16 | Last completed right sample |
| pair_valid | output | 1 | One-cycle strobe marking a new stereo pair on the outputs |

## Verification
The embedded properties check every cycle that the strobe never lasts more than one cycle, that the sample buses hold still without it, that the bit count never passes sixteen, that the padding state is only entered with a full word, and that a word-select change found while hunting starts a fresh word. Which words actually turn into pairs can only be shown by the bench scenarios: the MSB-first order and the one-slot delay, the choice between 16 and 32 slots with its padding, mid-stream rate switches, truncated words, and the suppression of partial frames after reset. The bench drives all of these and compares each cycle against a bit-queue model.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

    localparam int SAMPLE_BITS = 16;

    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_HUNT  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_PAD   = 2'd3
    } rx_state_e;

endpackage

// File: rtl/i2s_rx_ctrl.sv
module i2s_rx_ctrl
    import i2s_rx_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_BITS
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic ws,
    output logic shift_en,
    output logic word_done,
    output logic done_right,
    output logic start_left
);

    localparam int CNT_W = $clog2(SAMPLE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SAMPLE_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SAMPLE_W);

    rx_state_e        state, state_n;
    logic             ws_q;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             chan, chan_n;
    logic             ws_edge;

    assign ws_edge    = (state != ST_SYNC) && (ws != ws_q);
    assign done_right = chan;

    // state register
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SYNC;
            ws_q  <= 1'b0;
            cnt   <= '0;
            chan  <= 1'b0;
        end else begin
            state <= state_n;
            ws_q  <= ws;
            cnt   <= cnt_n;
            chan  <= chan_n;
        end
    end

    // next state and outputs
    always_comb begin
        state_n    = state;
        cnt_n      = cnt;
        chan_n     = chan;
        shift_en   = 1'b0;
        word_done  = 1'b0;
        start_left = 1'b0;
        unique case (state)
            ST_SYNC: begin
                state_n = ST_HUNT;
            end
            ST_HUNT: begin
                if (ws_edge) begin
                    state_n    = ST_SHIFT;
                    cnt_n      = '0;
                    chan_n     = ws;
                    start_left = !ws;
                end
            end
            ST_SHIFT: begin
                if (ws_edge) begin
                    if (cnt == LAST_BIT) begin
                        shift_en  = 1'b1;
                        word_done = 1'b1;
                    end
                    state_n    = ST_SHIFT;
                    cnt_n      = '0;
                    chan_n     = ws;
                    start_left = !ws;
                end else begin
                    shift_en = 1'b1;
                    cnt_n    = cnt + 1'b1;
                    if (cnt == LAST_BIT) begin
                        word_done = 1'b1;
                        state_n   = ST_PAD;
                    end
                end
            end
            ST_PAD: begin
                if (ws_edge) begin
                    state_n    = ST_SHIFT;
                    cnt_n      = '0;
                    chan_n     = ws;
                    start_left = !ws;
                end
            end
            default: state_n = ST_SYNC;
        endcase
    end

    // R10
    cnt_bound_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        cnt <= FULL_CNT);

    // R5
    pad_full_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        (state == ST_PAD) |-> (cnt == FULL_CNT));

    // R8
    hunt_exit_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        (state == ST_HUNT && ws != ws_q) |=> (state == ST_SHIFT && cnt == '0));

endmodule

// File: rtl/i2s_rx_shift.sv
module i2s_rx_shift
    import i2s_rx_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_BITS
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                sd,
    output logic [SAMPLE_W-1:0] word_next
);

    logic [SAMPLE_W-1:0] word_q;

    assign word_next = {word_q[SAMPLE_W-2:0], sd};

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (shift_en) begin
            word_q <= word_next;
        end
    end

endmodule

// File: rtl/i2s_rx_pair.sv
module i2s_rx_pair
    import i2s_rx_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_BITS
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                word_done,
    input  logic                done_right,
    input  logic                start_left,
    input  logic [SAMPLE_W-1:0] word_in,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                pair_valid
);

    logic [SAMPLE_W-1:0] left_hold;
    logic                left_ok;

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            left_hold  <= '0;
            left_ok    <= 1'b0;
            left_out   <= '0;
            right_out  <= '0;
            pair_valid <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            if (start_left) begin
                left_ok <= 1'b0;
            end
            if (word_done && !done_right) begin
                left_hold <= word_in;
                left_ok   <= 1'b1;
            end
            if (word_done && done_right && left_ok) begin
                left_out   <= left_hold;
                right_out  <= word_in;
                pair_valid <= 1'b1;
                left_ok    <= 1'b0;
            end
        end
    end

    // R7
    valid_pulse_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    // R7
    hold_outputs_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        !pair_valid |-> ($stable(left_out) && $stable(right_out)));

endmodule

// File: rtl/i2s_stereo_rx.sv
module i2s_stereo_rx
    import i2s_rx_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_BITS
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                ws,
    input  logic                sd,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                pair_valid
);

    logic                shift_en;
    logic                word_done;
    logic                done_right;
    logic                start_left;
    logic [SAMPLE_W-1:0] word_next;

    i2s_rx_ctrl #(.SAMPLE_W(SAMPLE_W)) ctrl_i (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .ws         (ws),
        .shift_en   (shift_en),
        .word_done  (word_done),
        .done_right (done_right),
        .start_left (start_left)
    );

    i2s_rx_shift #(.SAMPLE_W(SAMPLE_W)) shift_i (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .sd        (sd),
        .word_next (word_next)
    );

    i2s_rx_pair #(.SAMPLE_W(SAMPLE_W)) pair_i (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .word_done  (word_done),
        .done_right (done_right),
        .start_left (start_left),
        .word_in    (word_next),
        .left_out   (left_out),
        .right_out  (right_out),
        .pair_valid (pair_valid)
    );

endmodule

// File: tb/i2s_stereo_rx_tb_top.sv
module i2s_stereo_rx_tb_top;

    localparam int CLK_PERIOD = 20;
    localparam int W          = 16;
    localparam int WATCHDOG   = 20000;

    logic         bclk  = 1'b0;
    logic         rst_n = 1'b0;
    logic         ws    = 1'b0;
    logic         sd    = 1'b0;
    logic [W-1:0] left_out, right_out;
    logic         pair_valid;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    logic  carry = 1'b0;
    bit    run = 1'b0;
    int    pairs_phase = 0;
    logic [W-1:0] obs_l = '0, obs_r = '0;

    // reference model state
    bit     m_first = 1'b1;
    logic   m_prev = 1'b0;
    bit     m_active = 1'b0;
    logic   m_chan = 1'b0;
    bit     m_left_ok = 1'b0;
    logic [W-1:0] m_left = '0;
    bit     m_bits[$];
    logic         exp_valid = 1'b0;
    logic [W-1:0] exp_l = '0, exp_r = '0;

    always #(CLK_PERIOD/2) bclk = ~bclk;

    i2s_stereo_rx #(.SAMPLE_W(W)) dut_i (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .ws         (ws),
        .sd         (sd),
        .left_out   (left_out),
        .right_out  (right_out),
        .pair_valid (pair_valid)
    );

    function automatic void finish_word(input logic ch);
        logic [W-1:0] v = '0;
        foreach (m_bits[i]) v = {v[W-2:0], m_bits[i]};
        if (!ch) begin
            m_left    = v;
            m_left_ok = 1'b1;
        end else if (m_left_ok) begin
            exp_l     = m_left;
            exp_r     = v;
            exp_valid = 1'b1;
            m_left_ok = 1'b0;
        end
    endfunction

    // behavioural model: a queue of bits per word, reset on word-select change
    always @(posedge bclk) begin
        run = 1'b1;
        if (!rst_n) begin
            m_first = 1'b1; m_active = 1'b0; m_left_ok = 1'b0;
            m_bits.delete();
            exp_valid = 1'b0; exp_l = '0; exp_r = '0;
        end else begin
            exp_valid = 1'b0;
            if (m_first) begin
                m_prev  = ws;
                m_first = 1'b0;
            end else if (ws != m_prev) begin
                if (m_active && m_bits.size() == W-1) begin
                    m_bits.push_back(sd);
                    finish_word(m_chan);
                end
                m_bits.delete();
                m_active = 1'b1;
                m_chan   = ws;
                if (!ws) m_left_ok = 1'b0;
                m_prev   = ws;
            end else if (m_active && m_bits.size() < W) begin
                m_bits.push_back(sd);
                if (m_bits.size() == W) finish_word(m_chan);
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge bclk) begin
        if (run) begin
            checks++;
            if (pair_valid !== exp_valid || left_out !== exp_l || right_out !== exp_r) begin
                errors++;
                $display("FAIL %s/R7 cycle compare: valid=%0b L=%h R=%h expected valid=%0b L=%h R=%h",
                         cur_req, pair_valid, left_out, right_out, exp_valid, exp_l, exp_r);
            end
            if (pair_valid === 1'b1) begin
                pairs_phase++;
                obs_l = left_out;
                obs_r = right_out;
            end
        end
    end

    task automatic slot(input logic w, input logic d);
        @(negedge bclk);
        ws <= w;
        sd <= d;
    endtask

    function automatic logic seq_bit(input logic [W-1:0] word, input logic [W-1:0] pad, input int k);
        return (k < W) ? word[W-1-k] : pad[k-W];
    endfunction

    task automatic send_chan(input logic w, input logic [W-1:0] word, input int slots, input logic [W-1:0] pad);
        slot(w, carry);
        for (int i = 1; i < slots; i++) slot(w, seq_bit(word, pad, i-1));
        carry = seq_bit(word, pad, slots-1);
    endtask

    task automatic send_frame(input logic [W-1:0] l, input logic [W-1:0] r, input int slots, input logic [W-1:0] pad);
        send_chan(1'b0, l, slots, pad);
        send_chan(1'b1, r, slots, pad);
    endtask

    // deliver the pending bit, then idle on the right channel
    task automatic end_phase();
        slot(1'b0, carry);
        for (int i = 0; i < 20; i++) slot(1'b1, 1'b0);
        carry = 1'b0;
    endtask

    task automatic check_pairs(input string req, input int exp_n, input logic [W-1:0] el, input logic [W-1:0] er);
        checks++;
        if (pairs_phase != exp_n) begin
            errors++;
            $display("FAIL %s pair count: got %0d expected %0d", req, pairs_phase, exp_n);
        end
        if (exp_n > 0) begin
            checks++;
            if (obs_l !== el || obs_r !== er) begin
                errors++;
                $display("FAIL %s last pair: L=%h R=%h expected L=%h R=%h", req, obs_l, obs_r, el, er);
            end
        end
        pairs_phase = 0;
    endtask

    task automatic check_reset_state(input string req);
        @(negedge bclk);
        checks++;
        if (pair_valid !== 1'b0 || left_out !== '0 || right_out !== '0) begin
            errors++;
            $display("FAIL %s reset state: valid=%0b L=%h R=%h expected 0 0000 0000",
                     req, pair_valid, left_out, right_out);
        end
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (2) @(negedge bclk);
        check_reset_state("R1");
        @(negedge bclk);
        rst_n <= 1'b1;
        check_reset_state("R1");
        pairs_phase = 0;

        // R8: partial left after reset, then right, then one good frame
        cur_req = "R8";
        for (int i = 0; i < 7; i++) slot(1'b0, i[0]);
        send_chan(1'b1, 16'hBEEF, 16, '0);
        check_pairs("R8", 0, '0, '0);
        send_frame(16'h1357, 16'h2468, 16, '0);
        end_phase();
        check_pairs("R8", 1, 16'h1357, 16'h2468);

        // R2: channel mapping
        cur_req = "R2";
        send_frame(16'hFFFF, 16'h0000, 16, '0);
        end_phase();
        check_pairs("R2", 1, 16'hFFFF, 16'h0000);

        // R3 / R4: MSB first, 16 slots per channel
        cur_req = "R4";
        send_frame(16'h8001, 16'h7FFE, 16, '0);
        send_frame(16'hA5A5, 16'h5A5A, 16, '0);
        send_frame(16'h0001, 16'h8000, 16, '0);
        send_frame(16'h1234, 16'hFEDC, 16, '0);
        end_phase();
        check_pairs("R4", 4, 16'h1234, 16'hFEDC);
        send_frame(16'h8000, 16'h0001, 16, '0);
        end_phase();
        check_pairs("R3", 1, 16'h8000, 16'h0001);

        // R5: 32 slots per channel with padding of ones and alternating bits
        cur_req = "R5";
        send_frame(16'h0000, 16'h0000, 32, 16'hFFFF);
        send_frame(16'hC3C3, 16'h3C3C, 32, 16'hAAAA);
        send_frame(16'h0F0F, 16'hF0F0, 32, 16'h5555);
        end_phase();
        check_pairs("R5", 3, 16'h0F0F, 16'hF0F0);

        // R6: rate switching with no reset
        cur_req = "R6";
        send_frame(16'h1111, 16'h2222, 16, '0);
        send_frame(16'h3333, 16'h4444, 32, 16'hFFFF);
        send_frame(16'h5555, 16'h6666, 16, '0);
        send_frame(16'h7777, 16'h8888, 32, 16'h0F0F);
        end_phase();
        check_pairs("R6", 4, 16'h7777, 16'h8888);

        // R9: truncated left word discards the frame
        cur_req = "R9";
        send_chan(1'b0, 16'hAAAA, 10, '0);
        send_chan(1'b1, 16'h5555, 16, '0);
        check_pairs("R9", 0, '0, '0);
        send_frame(16'h6789, 16'h9876, 32, 16'hA5A5);
        end_phase();
        check_pairs("R9", 1, 16'h6789, 16'h9876);

        // R10: truncated right word after a full left
        cur_req = "R10";
        send_chan(1'b0, 16'h4321, 16, '0);
        send_chan(1'b1, 16'hFFFF, 12, '0);
        send_chan(1'b0, 16'hFFFF, 32, 16'hFFFF);
        send_chan(1'b1, 16'hEEEE, 32, 16'hFFFF);
        end_phase();
        check_pairs("R10", 1, 16'hFFFF, 16'hEEEE);

        // R8: reset in mid-stream, then start inside a right word
        cur_req = "R8";
        send_chan(1'b0, 16'h1111, 16, '0);
        @(negedge bclk);
        rst_n <= 1'b0;
        check_reset_state("R1");
        @(negedge bclk);
        rst_n <= 1'b1;
        ws    <= 1'b1;
        pairs_phase = 0;
        carry = 1'b0;
        for (int i = 0; i < 5; i++) slot(1'b1, 1'b1);
        send_frame(16'hCAFE, 16'hF00D, 16, '0);
        end_phase();
        check_pairs("R8", 1, 16'hCAFE, 16'hF00D);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge bclk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion within %0d cycles", WATCHDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule